// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position held in a 16-bit wrapping counter. Each raw phase input passes through a two-stage synchronizer and then an optional debounce stage. The debounce stage accepts a new level only after the synchronized input has held that level for four consecutive clocks. A decoder state machine keeps the last accepted phase pair and compares it with the current pair to produce one of four step outcomes: none, up, down or illegal.

The `mode_x4` input is a runtime selector. When it is low (two-edge counting), only transitions of phase A move the counter. When it is high (four-edge counting), every legal Gray-code transition of the pair moves it. An index pulse on `clr` zeroes the position. A periodic `cap` strobe copies the position into a holding register, so that a consumer can take differences between successive samples for speed.

The decoder has four states, named after the accepted levels {A,B}: `PH_00`, `PH_10`, `PH_11` and `PH_01`. The forward cycle is PH_00→PH_10→PH_11→PH_01→PH_00. Each transition in that order is a forward step. The same transitions taken in reverse are backward steps. A transition between diagonal states (PH_00↔PH_11 or PH_10↔PH_01) is illegal. Holding in the same state is idle. In every case the state register loads the current pair.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, `count`, `cap_val`, `dir` and `err` are all zero, and the decoder state is PH_00.
- R2: With `filt_en`=1, an input pulse of 3 clocks or fewer is ignored: the count does not move and no error is raised. A pulse of 4 clocks is accepted.
- R3: With `mode_x4`=1, each forward transition (A leads B; {A,B} 00→10→11→01→00) adds one to `count` and sets `dir`=1.
- R4: With `mode_x4`=1, each backward transition (B leads A) subtracts one from `count` and sets `dir`=0.
- R5: With `mode_x4`=0, every edge of A counts. The step is up when the new A differs from B, and down when the new A equals B. A full forward cycle therefore adds 2.
- R6: With `mode_x4`=0, an edge of B alone leaves `count` unchanged.
- R7: If A and B both change between two accepted samples, in either mode, `count` is unchanged and `err` becomes 1. `err` then stays at 1 until reset.
- R8: `count` wraps modulo 2^16: one step down from 0x0000 gives 0xFFFF, and one step up from 0xFFFF gives 0x0000.
- R9: `clr`=1 sets `count` to 0 on the next edge. If a step occurs in the same cycle, the clear wins.
- R10: `cap`=1 loads `cap_val` with the value `count` held before that cycle's update, including in a cycle that also steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | Raw phase A |
| b_in | input | 1 | Raw phase B |
| filt_en | input | 1 | 1 enables the 4-clock debounce on both phases |
| mode_x4 | input | 1 | 0 = count A edges only, 1 = count every edge |
| clr | input | 1 | Synchronous clear of the position (index pulse) |
| cap | input | 1 | Capture strobe |
| count | output | 16 | Current position |
| dir | output | 1 | Sign of last step: 1 up, 0 down |
| cap_val | output | 16 | Last captured position |
| err | output | 1 | Sticky illegal-transition flag |

## Verification
A step can land in the same cycle as either the index clear or the capture strobe, and both coincidences are provoked on purpose. The bench changes phase A on a falling clock edge and counts the three register stages between the pin and the decoder. It then raises `clr` or `cap` exactly for the cycle in which the step reaches the counter. The clear case passes only if the position reads zero rather than the stepped value. The capture case passes only if the holding register shows the pre-step value while the position shows the stepped one.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Decoder state: accepted levels, bit1 = A, bit0 = B
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;

    // Successor of a phase in the forward direction
    function automatic phase_t fwd_next(input phase_t p);
        phase_t n;
        unique case (p)
            PH_00: n = PH_10;
            PH_10: n = PH_11;
            PH_11: n = PH_01;
            PH_01: n = PH_00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/qpc_input_cond.sv
module qpc_input_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic filt_en_i,
    output logic lvl_o
);
    localparam int HIST_W = FILT_LEN - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST_W-1:0]      hist_q;
    logic                   s_lvl;
    logic [FILT_LEN-1:0]    window;
    logic                   steady;

    assign s_lvl  = sync_q[SYNC_STAGES-1];
    assign window = {hist_q, s_lvl};
    assign steady = (&window) | ~(|window);

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= raw_i;
            end
        end
    endgenerate

    generate
        if (HIST_W > 1) begin : g_hist
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= {hist_q[HIST_W-2:0], s_lvl};
            end
        end else begin : g_hist1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hist_q <= '0;
                else        hist_q <= s_lvl;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          lvl_o <= 1'b0;
        else if (!filt_en_i) lvl_o <= s_lvl;
        else if (steady)     lvl_o <= s_lvl;
    end

    // R2: with the filter on, a change of output needs a full steady window behind it
    p_filter_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en_i && $past(filt_en_i) && $changed(lvl_o)) |-> $past(steady));

endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  a_i,
    input  logic  b_i,
    input  logic  mode_x4_i,
    output step_t step_o
);
    phase_t state_q;
    phase_t now_ph;
    logic   a_moved;
    logic   b_moved;

    assign now_ph  = phase_t'({a_i, b_i});
    assign a_moved = state_q[1] ^ a_i;
    assign b_moved = state_q[0] ^ b_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= now_ph;
    end

    // Step output
    always_comb begin
        step_o = STEP_NONE;
        unique case ({a_moved, b_moved})
            2'b00: step_o = STEP_NONE;
            2'b11: step_o = STEP_BAD;
            2'b10: begin
                if (mode_x4_i) step_o = (now_ph == fwd_next(state_q)) ? STEP_UP : STEP_DOWN;
                else           step_o = (a_i != b_i) ? STEP_UP : STEP_DOWN;
            end
            2'b01: begin
                if (mode_x4_i) step_o = (now_ph == fwd_next(state_q)) ? STEP_UP : STEP_DOWN;
                else           step_o = STEP_NONE;
            end
        endcase
    end

    p_x2_b_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_x4_i && (a_i == state_q[1])) |-> (step_o == STEP_NONE));

    p_diag_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PH_00 && now_ph == PH_11) || (state_q == PH_10 && now_ph == PH_01))
        |-> (step_o == STEP_BAD));

    p_fwd_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_x4_i && state_q == PH_10 && now_ph == PH_11) |-> (step_o == STEP_UP));

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
    import qpc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_t        step_i,
    input  logic         clr_i,
    input  logic         cap_i,
    output logic [W-1:0] count_o,
    output logic         dir_o,
    output logic [W-1:0] cap_o,
    output logic         err_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else begin
            unique case (step_i)
                STEP_UP:   count_o <= count_o + ONE;
                STEP_DOWN: count_o <= count_o - ONE;
                default:   count_o <= count_o;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dir_o <= 1'b0;
        else if (step_i == STEP_UP)   dir_o <= 1'b1;
        else if (step_i == STEP_DOWN) dir_o <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cap_o <= '0;
        else if (cap_i) cap_o <= count_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  err_o <= 1'b0;
        else if (step_i == STEP_BAD) err_o <= 1'b1;
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    p_up_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i == STEP_UP) |=> (count_o == $past(count_o) + ONE));

    p_down_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i == STEP_DOWN) |=> (count_o == $past(count_o) - ONE));

    p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i == STEP_BAD) |=> ($stable(count_o) && err_o));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_cap_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (cap_o == $past(count_o)));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_in,
    input  logic         b_in,
    input  logic         filt_en,
    input  logic         mode_x4,
    input  logic         clr,
    input  logic         cap,
    output logic [W-1:0] count,
    output logic         dir,
    output logic [W-1:0] cap_val,
    output logic         err
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_v;
    logic [NCH-1:0] lvl_v;
    step_t          step;

    assign raw_v = {a_in, b_in};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_in
            qpc_input_cond #(
                .SYNC_STAGES(SYNC_STAGES),
                .FILT_LEN   (FILT_LEN)
            ) u_cond (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_i    (raw_v[ch]),
                .filt_en_i(filt_en),
                .lvl_o    (lvl_v[ch])
            );
        end
    endgenerate

    qpc_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (lvl_v[1]),
        .b_i      (lvl_v[0]),
        .mode_x4_i(mode_x4),
        .step_o   (step)
    );

    qpc_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .clr_i  (clr),
        .cap_i  (cap),
        .count_o(count),
        .dir_o  (dir),
        .cap_o  (cap_val),
        .err_o  (err)
    );

    p_dir_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_UP) |=> dir);

    p_dir_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_DOWN) |=> !dir);

endmodule

// File: tb/quad_pos_counter_tb.sv
module quad_pos_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_in = 1'b0, b_in = 1'b0;
    logic        filt_en = 1'b0, mode_x4 = 1'b0, clr = 1'b0, cap = 1'b0;
    logic [15:0] count, cap_val;
    logic        dir, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pos_counter u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .filt_en(filt_en), .mode_x4(mode_x4), .clr(clr), .cap(cap),
        .count(count), .dir(dir), .cap_val(cap_val), .err(err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic x4, input logic fe);
        @(negedge clk);
        rst_n = 1'b0; a_in = 0; b_in = 0; clr = 0; cap = 0;
        mode_x4 = x4; filt_en = fe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_ab(input logic a, input logic b);
        @(negedge clk);
        a_in = a; b_in = b;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1, 1'b0);
        check("R1 count", count, 16'h0);
        check("R1 cap_val", cap_val, 16'h0);
        check("R1 dir", {15'b0, dir}, 16'h0);
        check("R1 err", {15'b0, err}, 16'h0);
    endtask

    task automatic t_x4_dirs;
        do_reset(1'b1, 1'b0);
        set_ab(1, 0); check("R3 first fwd", count, 16'd1);
        check("R3 dir up", {15'b0, dir}, 16'd1);
        set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
        check("R3 full fwd cycle", count, 16'd4);
        set_ab(0, 1); check("R4 first back", count, 16'd3);
        check("R4 dir down", {15'b0, dir}, 16'd0);
        set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
        check("R4 back to zero", count, 16'd0);
        set_ab(0, 1); check("R8 wrap down", count, 16'hFFFF);
        set_ab(0, 0); check("R8 wrap up", count, 16'h0000);
    endtask

    task automatic t_x2;
        do_reset(1'b0, 1'b0);
        set_ab(1, 0); check("R5 A rise fwd", count, 16'd1);
        set_ab(1, 1); check("R6 B only ignored", count, 16'd1);
        set_ab(0, 1); check("R5 A fall fwd", count, 16'd2);
        set_ab(0, 0); check("R6 B fall ignored", count, 16'd2);
        set_ab(0, 1); set_ab(1, 1);
        check("R5 A rise back", count, 16'd1);
        check("R5 dir down", {15'b0, dir}, 16'd0);
    endtask

    task automatic t_illegal;
        do_reset(1'b1, 1'b0);
        set_ab(1, 1);
        check("R7 count held", count, 16'd0);
        check("R7 err set", {15'b0, err}, 16'd1);
        set_ab(1, 0);
        check("R7 legal after bad", count, 16'hFFFF);
        check("R7 err sticky", {15'b0, err}, 16'd1);
    endtask

    // Step reaches the counter on the 4th rising edge after the input is driven
    task automatic t_clear;
        do_reset(1'b1, 1'b0);
        set_ab(1, 0); set_ab(1, 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R9 plain clear", count, 16'd0);
        set_ab(0, 1); set_ab(0, 0);
        check("R9 pre-collision", count, 16'd2);
        @(negedge clk); a_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R9 clear beats step", count, 16'd0);
        repeat (6) @(negedge clk);
        check("R9 no late step", count, 16'd0);
    endtask

    task automatic t_capture;
        do_reset(1'b1, 1'b0);
        set_ab(1, 0); set_ab(1, 1);
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        check("R10 plain capture", cap_val, 16'd2);
        @(negedge clk); a_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        check("R10 pre-step value", cap_val, 16'd2);
        check("R10 count stepped", count, 16'd3);
    endtask

    task automatic t_filter;
        logic [15:0] peak;
        do_reset(1'b1, 1'b1);
        peak = 16'h0;
        @(negedge clk); a_in = 1'b1;
        repeat (3) @(negedge clk);
        a_in = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (count != 16'h0) peak = count;
        end
        check("R2 3-clock pulse rejected", peak, 16'h0);
        peak = 16'h0;
        @(negedge clk); a_in = 1'b1;
        repeat (4) @(negedge clk);
        a_in = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (count == 16'd1) peak = 16'd1;
        end
        check("R2 4-clock pulse accepted", peak, 16'd1);
        check("R2 pulse returned", count, 16'h0);
        @(negedge clk); a_in = 1'b1; b_in = 1'b1;
        repeat (3) @(negedge clk);
        a_in = 1'b0; b_in = 1'b0;
        repeat (15) @(negedge clk);
        check("R2 filtered no error", {15'b0, err}, 16'd0);
        do_reset(1'b1, 1'b0);
        @(negedge clk); a_in = 1'b1; b_in = 1'b1;
        repeat (3) @(negedge clk);
        a_in = 1'b0; b_in = 1'b0;
        repeat (15) @(negedge clk);
        check("R7 unfiltered glitch errors", {15'b0, err}, 16'd1);
    endtask

    initial begin
        t_reset();
        t_x4_dirs();
        t_x2();
        t_illegal();
        t_clear();
        t_capture();
        t_filter();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule